// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a processor core's dedicated control pins and the core itself. It watches a vector of already synchronized pin levels. It keeps a register holding the level each pin had at the previous clock. It acts only when a pin's new level differs from that register. Each defined pin has its own sensing rule: active-high level, active-low level, or falling edge. The rule decides what the pin does. A pin can set or clear a bit of a pending-interrupt vector, start or freeze the time base, stop the core, or hold the core in reset.

The pending vector has four bits: external interrupt (bit 0), system-management interrupt (bit 1), machine check (bit 2) and soft reset (bit 3). A single request line tells the core that at least one pending bit is set. The core acknowledges a bit by pulsing the matching bit of the clear port.

The core run control is a three-state machine:
- `CORE_RUN` is the reset state.
- `CORE_HALT` is entered from `CORE_RUN` on a checkstop assertion.
- `CORE_RESET` is entered from `CORE_RUN` or `CORE_HALT` when the hard reset pin falls.
- The machine leaves `CORE_RESET` for `CORE_RUN` when the hard reset pin rises.

No other transition exists, so a halted core leaves `CORE_HALT` only through `CORE_RESET`.

Pin map:

| Index | Pin | Sensing rule |
|---|---|---|
| 0 | time-base enable | active high |
| 1 | external interrupt | active high |
| 2 | system-management interrupt | active high |
| 3 | machine check | falling edge |
| 4 | checkstop | active low |
| 5 | hard reset | active low |
| 6 | soft reset | active high |
| 7 and above | spare | none |

Every output is registered. An effect shows one clock after the edge that samples the pin change.

Top module: `irq_pin_conditioner`

## Requirements
- R1: The block acts on a pin only in a cycle where the pin's level differs from the level recorded at the previous clock. A pending bit cleared by the core while its level pin stays asserted therefore stays clear.
- R2: A change on pin 0 (time-base enable) copies the new level into `tb_run`: 1 lets the time base run and 0 freezes it.
- R3: A change on pin 1 (external interrupt) or pin 2 (system-management interrupt) writes the new level into pending bit 0 or pending bit 1 respectively.
- R4: A 1-to-0 change on pin 3 (machine check) sets pending bit 2. A 0-to-1 change on pin 3 leaves the pending vector unchanged.
- R5: A 1-to-0 change on pin 4 (checkstop, active low) moves `CORE_RUN` to `CORE_HALT`, which drives `core_halt` high. A later rise on pin 4 does not release it; only the hard reset path does.
- R6: A 1-to-0 change on pin 5 (hard reset, active low) moves the machine to `CORE_RESET` from any state, which drives `core_rst` high and `core_halt` low. A 0-to-1 change on pin 5 then returns it to `CORE_RUN`.
- R7: A change on pin 6 (soft reset) writes the new level into pending bit 3.
- R8: `irq_req` is 1 exactly when the pending vector is non-zero, and it drops only when every pending bit is zero.
- R9: Changes on pin indices 7 and above have no effect on any output.
- R10: A 1 on `pend_clr[i]` clears pending bit i. If a pin event writes bit i in the same cycle, the pin event wins.
- R11: While `rst_n` is low:
  - every pending bit, `irq_req`, `tb_run`, `core_halt` and `core_rst` are 0;
  - the recorded levels are 1 for pins 3, 4 and 5 and 0 for all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| pend_clr | input | 4 | Per-bit clear of the pending vector |
| pend | output | 4 | Pending bits: external, system-management, machine check, soft reset |
| irq_req | output | 1 | Combined interrupt request to the core |
| tb_run | output | 1 | Time-base run enable |
| core_halt | output | 1 | Core stopped by checkstop |
| core_rst | output | 1 | Core hard reset request |

## Verification
The hardest case to reach is a clash between the core's clear and a pin event in the same clock.

Two variants matter:
- A machine-check falling edge that lands on the very cycle the core clears bit 2.
- A level pin that is still asserted after its bit was cleared, so no new event may re-raise it.

Directed steps drive the clear pulse and the pin change on the same falling clock edge, and hold the level pin for extra cycles afterwards. A long random phase follows. It toggles every pin, including the spare pin, and sends sparse clear pulses, with the hard reset pin asserted only rarely. This lets halt, reset and pending traffic interleave, and a behavioural model checks every output on every clock.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
    // pin positions on the input vector
    localparam int PIN_TB     = 0;
    localparam int PIN_EXT    = 1;
    localparam int PIN_SMI    = 2;
    localparam int PIN_MCK    = 3;
    localparam int PIN_STOP_N = 4;
    localparam int PIN_HRST_N = 5;
    localparam int PIN_SRST   = 6;
    localparam int PIN_DEF    = 7;   // number of defined pins

    // pending vector layout
    localparam int PEND_W  = 4;
    localparam int PND_EXT = 0;
    localparam int PND_SMI = 1;
    localparam int PND_MCK = 2;
    localparam int PND_RST = 3;

    typedef enum logic [1:0] {
        CORE_RUN   = 2'd0,
        CORE_HALT  = 2'd1,
        CORE_RESET = 2'd2
    } core_state_e;

    // which pin feeds a pending bit
    function automatic int pend_src_pin(input int b);
        case (b)
            PND_EXT: return PIN_EXT;
            PND_SMI: return PIN_SMI;
            PND_MCK: return PIN_MCK;
            default: return PIN_SRST;
        endcase
    endfunction

    // pending bit set by a falling edge instead of following a level
    function automatic bit pend_is_edge(input int b);
        return b == PND_MCK;
    endfunction

    // pins whose idle level is high
    function automatic bit pin_idles_high(input int p);
        return (p == PIN_MCK) || (p == PIN_STOP_N) || (p == PIN_HRST_N);
    endfunction
endpackage

// File: rtl/pinc_edge.sv
module pinc_edge #(
    parameter int          W    = 8,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] rec_q;

    // every pin, defined or not, has its level recorded
    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= IDLE;
        else        rec_q <= lvl;
    end

    assign chg = lvl ^ rec_q;
endmodule

// File: rtl/pinc_pend.sv
module pinc_pend
    import pinc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] evt_lvl,
    input  logic [PEND_W-1:0] evt_chg,
    input  logic [PEND_W-1:0] clr,
    output logic [PEND_W-1:0] pend_q,
    output logic              irq_q
);
    logic [PEND_W-1:0] pend_nxt;

    for (genvar b = 0; b < PEND_W; b++) begin : g_bit
        if (pend_is_edge(b)) begin : g_fall
            // falling edge sets; otherwise hold unless cleared
            assign pend_nxt[b] = (evt_chg[b] & ~evt_lvl[b]) | (pend_q[b] & ~clr[b]);
        end else begin : g_level
            // a level change overrides the clear
            assign pend_nxt[b] = evt_chg[b] ? evt_lvl[b] : (pend_q[b] & ~clr[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            irq_q  <= |pend_nxt;
        end
    end
endmodule

// File: rtl/pinc_core_fsm.sv
module pinc_core_fsm
    import pinc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_chg,
    input  logic stop_lvl,
    input  logic hrst_chg,
    input  logic hrst_lvl,
    output logic halt,
    output logic rst_req
);
    core_state_e st_q, st_nxt;
    logic hrst_fall, hrst_rise, stop_fall;

    assign hrst_fall = hrst_chg & ~hrst_lvl;
    assign hrst_rise = hrst_chg &  hrst_lvl;
    assign stop_fall = stop_chg & ~stop_lvl;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CORE_RUN: begin
                if (hrst_fall)      st_nxt = CORE_RESET;
                else if (stop_fall) st_nxt = CORE_HALT;
            end
            CORE_HALT: begin
                if (hrst_fall) st_nxt = CORE_RESET;
            end
            CORE_RESET: begin
                if (hrst_rise) st_nxt = CORE_RUN;
            end
            default: st_nxt = CORE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CORE_RUN;
        else        st_q <= st_nxt;
    end

    always_comb begin
        halt    = 1'b0;
        rst_req = 1'b0;
        unique case (st_q)
            CORE_HALT:  halt    = 1'b1;
            CORE_RESET: rst_req = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_pin_conditioner.sv
module irq_pin_conditioner
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [PEND_W-1:0]   pend_clr,
    output logic [PEND_W-1:0]   pend,
    output logic                irq_req,
    output logic                tb_run,
    output logic                core_halt,
    output logic                core_rst
);
    function automatic logic [NUM_PINS-1:0] idle_levels();
        logic [NUM_PINS-1:0] v;
        for (int p = 0; p < NUM_PINS; p++) v[p] = pin_idles_high(p);
        return v;
    endfunction

    localparam logic [NUM_PINS-1:0] REC_IDLE = idle_levels();

    logic [NUM_PINS-1:0] chg;
    logic [PEND_W-1:0]   evt_lvl, evt_chg;

    pinc_edge #(.W(NUM_PINS), .IDLE(REC_IDLE)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .chg(chg)
    );

    for (genvar b = 0; b < PEND_W; b++) begin : g_route
        assign evt_lvl[b] = pin_lvl[pend_src_pin(b)];
        assign evt_chg[b] = chg[pend_src_pin(b)];
    end

    if (NUM_PINS > PIN_DEF) begin : g_spare
        // spare pins are recorded but drive nothing
        logic unused_spare;
        assign unused_spare = ^{chg[NUM_PINS-1:PIN_DEF], pin_lvl[NUM_PINS-1:PIN_DEF]};
    end

    pinc_pend pend_i (
        .clk(clk), .rst_n(rst_n), .evt_lvl(evt_lvl), .evt_chg(evt_chg),
        .clr(pend_clr), .pend_q(pend), .irq_q(irq_req)
    );

    pinc_core_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .stop_chg(chg[PIN_STOP_N]), .stop_lvl(pin_lvl[PIN_STOP_N]),
        .hrst_chg(chg[PIN_HRST_N]), .hrst_lvl(pin_lvl[PIN_HRST_N]),
        .halt(core_halt), .rst_req(core_rst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)            tb_run <= 1'b0;
        else if (chg[PIN_TB])  tb_run <= pin_lvl[PIN_TB];
    end
endmodule

// File: rtl/irq_pin_conditioner_chk.sv
module irq_pin_conditioner_chk
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_lvl,
    input logic [PEND_W-1:0]   pend,
    input logic                irq_req,
    input logic                tb_run,
    input logic                core_halt,
    input logic                core_rst
);
    AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (pend != '0)); // R8
    AST_MCK_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_lvl[PIN_MCK]) |=> pend[PND_MCK]); // R4
    AST_MCK_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[PND_MCK] && $rose(pin_lvl[PIN_MCK])) |=> !pend[PND_MCK]); // R4
    AST_TB_RISE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_lvl[PIN_TB]) |=> tb_run); // R2
    AST_TB_FALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_lvl[PIN_TB]) |=> !tb_run); // R2
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |=> (core_halt || core_rst)); // R5
    AST_HRST_FALL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_lvl[PIN_HRST_N]) |=> (core_rst && !core_halt)); // R6
endmodule

bind irq_pin_conditioner irq_pin_conditioner_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pend(pend),
    .irq_req(irq_req), .tb_run(tb_run), .core_halt(core_halt), .core_rst(core_rst)
);

// File: tb/irq_pin_conditioner_tb_top.sv
module irq_pin_conditioner_tb_top;
    localparam int CLK_P = 10;
    localparam int NP    = 8;
    localparam logic [NP-1:0] IDLE = 8'b0011_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = IDLE;
    logic [3:0]    clr = '0;
    logic [3:0]    pend;
    logic          irq_req, tb_run, core_halt, core_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_pin_conditioner #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .pend_clr(clr),
        .pend(pend), .irq_req(irq_req), .tb_run(tb_run),
        .core_halt(core_halt), .core_rst(core_rst)
    );

    // behavioural reference: 0 run, 1 halted, 2 in reset
    logic [NP-1:0] m_prev;
    logic [3:0]    m_pend;
    bit            m_tb;
    int            m_core;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = IDLE; m_pend = 4'b0; m_tb = 0; m_core = 0;
        end else begin
            logic [NP-1:0] moved;
            moved  = pins ^ m_prev;
            m_prev = pins;
            m_pend = m_pend & ~clr;
            if (moved[1]) m_pend[0] = pins[1];
            if (moved[2]) m_pend[1] = pins[2];
            if (moved[3] && !pins[3]) m_pend[2] = 1'b1;
            if (moved[6]) m_pend[3] = pins[6];
            if (moved[0]) m_tb = pins[0];
            if (moved[5] && !pins[5]) m_core = 2;
            else if (moved[5] && pins[5] && m_core == 2) m_core = 0;
            else if (moved[4] && !pins[4] && m_core == 0) m_core = 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 R4 R7 R10 pend", pend, m_pend);
            check("R8 irq_req", irq_req, m_pend != 0);
            check("R2 tb_run", tb_run, m_tb);
            check("R5 core_halt", core_halt, m_core == 1);
            check("R6 core_rst", core_rst, m_core == 2);
        end
    end

    task automatic drive(input logic [NP-1:0] p, input logic [3:0] c);
        pins = p; clr = c;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [NP-1:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 pend", pend, 0);
        check("R11 irq", irq_req, 0);
        check("R11 tb", tb_run, 0);
        check("R11 halt", core_halt, 0);
        check("R11 rst", core_rst, 0);

        p = IDLE;
        p[0] = 1; drive(p, 0); check("R2 run", tb_run, 1);
        p[0] = 0; drive(p, 0); check("R2 freeze", tb_run, 0);

        p[1] = 1; drive(p, 0); check("R3 ext set", pend, 4'b0001);
        check("R8 irq up", irq_req, 1);
        drive(p, 4'b0001); check("R10 clear", pend, 0);
        drive(p, 0); drive(p, 0);
        check("R1 no re-set while held", pend, 0);
        check("R8 irq down", irq_req, 0);
        p[1] = 0; drive(p, 0);
        p[2] = 1; drive(p, 0); check("R3 smi set", pend, 4'b0010);
        p[2] = 0; drive(p, 0); check("R3 smi clear", pend, 0);

        p[3] = 0; drive(p, 0); check("R4 fall sets", pend, 4'b0100);
        p[3] = 1; drive(p, 0); check("R4 rise keeps", pend, 4'b0100);
        drive(p, 4'b0100); check("R10 mck cleared", pend, 0);
        drive(p, 0); check("R4 high idle", pend, 0);
        p[3] = 0; drive(p, 4'b0100); check("R10 event wins", pend, 4'b0100);
        p[3] = 1; drive(p, 0);

        p[6] = 1; drive(p, 0); check("R7 soft reset", pend, 4'b1100);
        drive(p, 4'b1111); check("R10 clear all", pend, 0);
        check("R8 all clear", irq_req, 0);
        p[6] = 0; drive(p, 0); check("R7 low", pend, 0);

        p[7] = 1; drive(p, 0);
        check("R9 spare pend", pend, 0);
        check("R9 spare halt", core_halt, 0);
        check("R9 spare tb", tb_run, 0);
        p[7] = 0; drive(p, 0); check("R9 spare back", pend, 0);

        p[4] = 0; drive(p, 0); check("R5 halt", core_halt, 1);
        p[4] = 1; drive(p, 0); check("R5 stays halted", core_halt, 1);
        p[5] = 0; drive(p, 0); check("R6 reset", core_rst, 1);
        check("R6 halt cleared", core_halt, 0);
        p[5] = 1; drive(p, 0); check("R6 released", core_rst, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [NP-1:0] r;
            logic [3:0]    c;
            r = NP'($urandom);
            if (($urandom % 16) != 0) r[5] = 1'b1;
            c = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
            drive(r, c);
        end
        drive(IDLE, 0);
        drive(IDLE, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule